// File: doc/BRIEF.md
# System-Clocked SPI Master Controller

This block is a serial peripheral interface master that lives entirely in the system clock domain. The serial clock is never a clock net. A programmable half-period counter produces edge ticks, and the serial clock pin is a plain register that toggles on those ticks. Bytes to send are queued in a transmit FIFO. Each byte is shifted out most significant bit first, and at the same time a byte is shifted in from the slave and pushed into a receive FIFO. The link is full duplex.

Software or a host sequencer writes three configuration fields: the half-period divider, the clock mode, and the index of the slave to address. It then queues bytes and pulses `start`. The master asserts the selected active-low slave select and keeps transferring bytes while the transmit FIFO holds data. When the FIFO runs dry at a byte boundary it ends the transaction cleanly. Configuration writes are only taken while idle. A write during a transaction is discarded and flagged.

Top module: `spiHostMaster`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, the outputs hold their defaults whatever the inputs do: `ssN` all ones, `sclk`, `mosi`, `busy`, `cfgErr` and `byteDone` low, `rxEmpty` high and `txFull` low. The configuration resets to divider 0, mode 0 and slave 0, and writes or pushes made during reset are lost.
- R2: With divider value N (configuration address 0, all bits of `cfgData`), every pair of consecutive `sclk` edges inside a transaction is exactly N+1 system clocks apart. This holds across byte boundaries and for every N from 0 to 255.
- R3: Configuration address 1 sets the mode: `cfgData[1]` is clock polarity and `cfgData[0]` is clock phase. While idle, `sclk` rests at the polarity value and follows a mode change. With phase 0, `mosi` carries the first bit before the first edge, the master samples on leading edges and changes data on trailing edges. With phase 1, data changes on leading edges and is sampled on trailing edges.
- R4: Frames are 8 bits, MSB first, and full duplex. Each received byte enters the receive FIFO, whose head is shown on `rxData` while `rxEmpty` is low and is removed by `rxPop`.
- R5: The selected `ssN` line falls on the cycle after `start` is accepted. The first `sclk` edge follows N+1 cycles later, and `ssN` rises N+1 cycles after the last edge.
- R6: Configuration address 2 picks the slave index from the low bits of `cfgData`. During a transaction exactly `ssN[index]` is low; otherwise all lines are high.
- R7: `start` is accepted only when idle and the transmit FIFO is not empty. A transaction makes 16 `sclk` edges per byte and stops after the byte during which the transmit FIFO became empty.
- R8: A configuration write while `busy` is high produces a one-cycle `cfgErr` pulse on the next cycle and is discarded. A write while idle takes effect and raises no error.
- R9: `byteDone` pulses for one cycle per byte, in the same cycle as that byte's last `sclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Field select: 0 divider, 1 mode, 2 slave index |
| cfgData | input | 8 | Configuration write value |
| txPush | input | 1 | Push `txData` into the transmit FIFO |
| txData | input | 8 | Byte to queue |
| txFull | output | 1 | Transmit FIFO full |
| start | input | 1 | Begin a transaction |
| rxPop | input | 1 | Remove the receive FIFO head |
| rxData | output | 8 | Receive FIFO head |
| rxEmpty | output | 1 | Receive FIFO empty |
| busy | output | 1 | Transaction in progress |
| cfgErr | output | 1 | Pulse: configuration write rejected |
| byteDone | output | 1 | Pulse: a byte completed |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 4 | Active-low slave selects |

## Verification
The hardest situation to reach is a configuration write that lands in the middle of a live transaction. Its only lasting proof of rejection is the timing of later edges. The stimulus therefore starts a two-byte transfer with a small divider and writes a much larger divider partway through. It then measures every remaining edge gap against the old half-period. The other behaviour is swept over all four modes, several dividers including the minimum and maximum, every slave line and one to three bytes per transaction. A bench slave model samples and drives data according to the mode.

// File: rtl/spiHostPkg.sv
package spiHostPkg;

  // configuration field selectors
  localparam logic [1:0] CFG_DIVIDER = 2'd0;
  localparam logic [1:0] CFG_MODE    = 2'd1;
  localparam logic [1:0] CFG_SLAVE   = 2'd2;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_TRAIL = 2'd2
  } seqState_t;

  // strobes from sequencer to shift path
  typedef struct packed {
    logic loadByte;   // take transmit head into shifter
    logic preDrive;   // on load, put MSB on mosi at once (phase 0)
    logic toggleClk;  // serial clock edge this cycle
    logic shiftOut;   // present next bit on mosi
    logic sampleIn;   // capture miso
    logic pushRx;     // completed byte goes to receive FIFO
    logic parkClk;    // idle: hold sclk at polarity
  } spiStrobe_t;

endpackage

// File: rtl/spiHostFifo.sv
module spiHostFifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] level;
  logic doPush, doPop;

  assign empty  = (level == '0);
  assign full   = (level == DEPTH_C);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdata  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_FIFO_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= DEPTH_C); // R4

  AST_FIFO_POP_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !empty && !push) |=> (level == $past(level) - 1'b1)); // R4

endmodule

// File: rtl/spiHostCtl.sv
module spiHostCtl
  import spiHostPkg::*;
#(
  parameter int NUM_SLAVES = 4,
  parameter int DIV_W      = 8,
  parameter int FRAME_BITS = 8,
  parameter int SEL_W      = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [1:0]            cfgAddr,
  input  logic [DIV_W-1:0]      cfgData,
  input  logic                  start,
  input  logic                  txEmpty,
  output logic                  txPop,
  output spiStrobe_t            strobe,
  output logic                  cpol,
  output logic                  busy,
  output logic                  cfgErr,
  output logic                  byteDone,
  output logic [NUM_SLAVES-1:0] ssN
);

  localparam int EDGES     = 2 * FRAME_BITS;
  localparam int EDGE_W    = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  seqState_t         state;
  logic [DIV_W-1:0]  halfCnt;
  logic [DIV_W-1:0]  divQ;
  logic [EDGE_W-1:0] edgeIdx;
  logic [SEL_W-1:0]  selQ;
  logic              cpolQ, cphaQ;
  logic              cfgErrQ, byteDoneQ;
  logic              tick, atLast, isLead, accept, cfgTaken;

  assign busy     = (state != SEQ_IDLE);
  assign cpol     = cpolQ;
  assign cfgErr   = cfgErrQ;
  assign byteDone = byteDoneQ;
  assign tick     = (halfCnt == divQ);
  assign atLast   = (edgeIdx == LAST_EDGE);
  assign isLead   = ~edgeIdx[0];
  assign accept   = (state == SEQ_IDLE) && start && !txEmpty;
  assign cfgTaken = cfgWrEn && (state == SEQ_IDLE);

  // strobe generation
  always_comb begin
    strobe          = '0;
    strobe.parkClk  = (state == SEQ_IDLE);
    strobe.preDrive = ~cphaQ;
    txPop           = 1'b0;
    if (accept) begin
      strobe.loadByte = 1'b1;
      txPop           = 1'b1;
    end
    if (state == SEQ_SHIFT && tick) begin
      strobe.toggleClk = 1'b1;
      if (cphaQ) begin
        strobe.shiftOut = isLead;
        strobe.sampleIn = !isLead;
      end else begin
        strobe.sampleIn = isLead;
        strobe.shiftOut = !isLead && !atLast;
      end
      if (atLast) begin
        strobe.pushRx = 1'b1;
        if (!txEmpty) begin
          strobe.loadByte = 1'b1;
          txPop           = 1'b1;
        end
      end
    end
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      halfCnt <= '0;
      edgeIdx <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          halfCnt <= '0;
          edgeIdx <= '0;
          if (accept) state <= SEQ_SHIFT;
        end
        SEQ_SHIFT: begin
          if (tick) begin
            halfCnt <= '0;
            if (atLast) begin
              edgeIdx <= '0;
              if (txEmpty) state <= SEQ_TRAIL;
            end else begin
              edgeIdx <= edgeIdx + 1'b1;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        SEQ_TRAIL: begin
          if (tick) begin
            halfCnt <= '0;
            state   <= SEQ_IDLE;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // configuration fields, writable only while idle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ      <= '0;
      cpolQ     <= 1'b0;
      cphaQ     <= 1'b0;
      selQ      <= '0;
      cfgErrQ   <= 1'b0;
      byteDoneQ <= 1'b0;
    end else begin
      cfgErrQ   <= cfgWrEn && busy;
      byteDoneQ <= (state == SEQ_SHIFT) && tick && atLast;
      if (cfgTaken) begin
        case (cfgAddr)
          CFG_DIVIDER: divQ <= cfgData;
          CFG_MODE: begin
            cpolQ <= cfgData[1];
            cphaQ <= cfgData[0];
          end
          CFG_SLAVE: selQ <= cfgData[SEL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // one select line per slave
  for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_sel
    assign ssN[i] = !(busy && (selQ == SEL_W'(i)));
  end

  AST_START_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start && !txEmpty)); // R7

  AST_CFG_ERR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> $past(cfgWrEn && busy)); // R8

  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(divQ) && $stable(cpolQ) && $stable(cphaQ) && $stable(selQ))); // R8

endmodule

// File: rtl/spiHostPath.sv
module spiHostPath
  import spiHostPkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  spiStrobe_t            strobe,
  input  logic                  cpol,
  input  logic [FRAME_BITS-1:0] txHead,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  mosi,
  output logic [FRAME_BITS-1:0] rxWord
);

  localparam int MSB = FRAME_BITS - 1;

  logic                  sclkQ, mosiQ;
  logic [FRAME_BITS-1:0] txSh, rxSh;

  assign sclk   = sclkQ;
  assign mosi   = mosiQ;
  assign rxWord = strobe.sampleIn ? {rxSh[MSB-1:0], miso} : rxSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      mosiQ <= 1'b0;
      txSh  <= '0;
      rxSh  <= '0;
    end else begin
      if (strobe.parkClk)        sclkQ <= cpol;
      else if (strobe.toggleClk) sclkQ <= ~sclkQ;

      if (strobe.loadByte) begin
        if (strobe.preDrive) begin
          mosiQ <= txHead[MSB];
          txSh  <= {txHead[MSB-1:0], 1'b0};
        end else begin
          txSh  <= txHead;
        end
      end else if (strobe.shiftOut) begin
        mosiQ <= txSh[MSB];
        txSh  <= {txSh[MSB-1:0], 1'b0};
      end

      if (strobe.sampleIn) rxSh <= {rxSh[MSB-1:0], miso};
    end
  end

  AST_DATA_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftOut || strobe.sampleIn) |-> strobe.toggleClk); // R3

  AST_NO_EDGE_WHILE_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.parkClk |-> !strobe.toggleClk); // R3

endmodule

// File: rtl/spiHostMaster.sv
module spiHostMaster
  import spiHostPkg::*;
#(
  parameter int NUM_SLAVES = 4,
  parameter int DIV_W      = 8,
  parameter int FRAME_BITS = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [1:0]            cfgAddr,
  input  logic [DIV_W-1:0]      cfgData,
  input  logic                  txPush,
  input  logic [FRAME_BITS-1:0] txData,
  output logic                  txFull,
  input  logic                  start,
  input  logic                  rxPop,
  output logic [FRAME_BITS-1:0] rxData,
  output logic                  rxEmpty,
  output logic                  busy,
  output logic                  cfgErr,
  output logic                  byteDone,
  output logic                  sclk,
  output logic                  mosi,
  input  logic                  miso,
  output logic [NUM_SLAVES-1:0] ssN
);

  spiStrobe_t            strobe;
  logic                  txPop, txEmpty, rxFull, cpol;
  logic [FRAME_BITS-1:0] txHead, rxWord;

  spiHostFifo #(.WIDTH(FRAME_BITS), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN),
    .push(txPush), .wdata(txData),
    .pop(txPop), .rdata(txHead),
    .empty(txEmpty), .full(txFull)
  );

  spiHostFifo #(.WIDTH(FRAME_BITS), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .push(strobe.pushRx && !rxFull), .wdata(rxWord),
    .pop(rxPop), .rdata(rxData),
    .empty(rxEmpty), .full(rxFull)
  );

  spiHostCtl #(.NUM_SLAVES(NUM_SLAVES), .DIV_W(DIV_W), .FRAME_BITS(FRAME_BITS)) u_ctl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .start(start), .txEmpty(txEmpty), .txPop(txPop),
    .strobe(strobe), .cpol(cpol),
    .busy(busy), .cfgErr(cfgErr), .byteDone(byteDone), .ssN(ssN)
  );

  spiHostPath #(.FRAME_BITS(FRAME_BITS)) u_path (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .cpol(cpol), .txHead(txHead), .miso(miso),
    .sclk(sclk), .mosi(mosi), .rxWord(rxWord)
  );

  AST_SS_ONE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~ssN) == (busy ? 1 : 0)); // R6

  AST_IDLE_CLK_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol)); // R3

  AST_DONE_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> (sclk != $past(sclk))); // R9

endmodule

// File: tb/sim_spiHostMaster.sv
module sim_spiHostMaster;

  localparam int CLK_PERIOD = 10;
  localparam int NSL        = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic       txPush = 1'b0;
  logic [7:0] txData = '0;
  logic       start = 1'b0;
  logic       rxPop = 1'b0;
  logic       miso = 1'b0;
  logic       txFull, rxEmpty, busy, cfgErr, byteDone, sclk, mosi;
  logic [7:0] rxData;
  logic [NSL-1:0] ssN;

  spiHostMaster u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .txPush(txPush), .txData(txData), .txFull(txFull), .start(start),
    .rxPop(rxPop), .rxData(rxData), .rxEmpty(rxEmpty), .busy(busy),
    .cfgErr(cfgErr), .byteDone(byteDone), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ssN(ssN)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // expected configuration as the bench intends it
  logic expCpol = 1'b0, expCpha = 1'b0;
  int   expHalf = 1;
  int   expSel  = 0;
  int   seed    = 0;

  // bench slave model state and measurements
  logic       prevSclk = 1'b0, prevAct = 1'b0;
  logic [7:0] slvTx = '0, slvRx = '0;
  int bitCnt = 0, slvIdx = 0, gotN = 0, edgeCount = 0;
  int lastEdgeCyc = 0, ssFallCyc = 0;
  int gapErrs = 0, leadErrs = 0, trailErrs = 0, selErrs = 0, doneCount = 0;
  logic [7:0] gotBytes [8];

  function automatic logic [7:0] txVal(int s, int i);
    return 8'((s * 13) + (i * 71) + 5);
  endfunction
  function automatic logic [7:0] respVal(int s, int i);
    return 8'((s * 7) + (i * 53) + 8'h91);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      automatic logic act = (ssN != '1);
      if (act && ((~ssN) != NSL'(1 << expSel))) selErrs++;
      if (act && !prevAct) begin
        ssFallCyc = cyc;
        bitCnt = 0;
        edgeCount = 0;
        if (!expCpha) begin
          slvTx = respVal(seed, slvIdx);
          slvIdx++;
          miso <= slvTx[7];
          slvTx = {slvTx[6:0], 1'b0};
        end
      end else if (!act && prevAct) begin
        if (cyc - lastEdgeCyc != expHalf) trailErrs++;
      end else if (act && (sclk !== prevSclk)) begin
        automatic logic lead = (sclk != expCpol);
        if (edgeCount == 0) begin
          if (cyc - ssFallCyc != expHalf) leadErrs++;
        end else if (cyc - lastEdgeCyc != expHalf) gapErrs++;
        lastEdgeCyc = cyc;
        edgeCount++;
        if (lead == !expCpha) begin
          slvRx = {slvRx[6:0], mosi};
          bitCnt++;
          if (bitCnt == 8) begin
            if (gotN < 8) gotBytes[gotN] = slvRx;
            gotN++;
            bitCnt = 0;
          end
        end else begin
          if ((expCpha && bitCnt == 0) || (!expCpha && bitCnt == 0)) begin
            slvTx = respVal(seed, slvIdx);
            slvIdx++;
          end
          miso <= slvTx[7];
          slvTx = {slvTx[6:0], 1'b0};
        end
      end
      if (byteDone) doneCount++;
      prevAct = act;
    end
    prevSclk = sclk;
  end

  task automatic cfgWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic pushByte(logic [7:0] d);
    @(negedge clk);
    txPush = 1'b1; txData = d;
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic clearModel();
    gotN = 0; slvIdx = 0; gapErrs = 0; leadErrs = 0; trailErrs = 0;
    selErrs = 0; doneCount = 0; edgeCount = 0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
    @(negedge clk);
  endtask

  task automatic checkTransfer(int n, string tag);
    check(edgeCount == 16 * n, "R7", {tag, " edge count"}, edgeCount, 16 * n);
    check(gapErrs == 0, "R2", {tag, " edge spacing"}, gapErrs, 0);
    check(leadErrs == 0 && trailErrs == 0, "R5", {tag, " select lead/trail"}, leadErrs + trailErrs, 0);
    check(selErrs == 0, "R6", {tag, " select line"}, selErrs, 0);
    check(doneCount == n, "R9", {tag, " done pulses"}, doneCount, n);
    check(gotN == n, "R4", {tag, " bytes seen by slave"}, gotN, n);
    for (int i = 0; i < n && i < 8; i++)
      check(gotBytes[i] == txVal(seed, i), "R4 R3", {tag, " mosi byte"}, gotBytes[i], txVal(seed, i));
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!rxEmpty && rxData == respVal(seed, i), "R4 R3", {tag, " miso byte"}, rxData, respVal(seed, i));
      rxPop = 1'b1;
      @(negedge clk);
      rxPop = 1'b0;
    end
    check(rxEmpty, "R4", {tag, " rx drained"}, rxEmpty, 1);
  endtask

  task automatic doTransfer(int mode, int dv, int sel, int n);
    cfgWrite(2'd0, 8'(dv));
    cfgWrite(2'd1, 8'(mode));
    cfgWrite(2'd2, 8'(sel));
    check(!cfgErr, "R8", "idle write flagged", cfgErr, 0);
    expCpol = mode[1]; expCpha = mode[0]; expHalf = dv + 1; expSel = sel;
    seed++;
    for (int i = 0; i < n; i++) pushByte(txVal(seed, i));
    @(negedge clk);
    check(sclk == expCpol && ssN == '1, "R3", "idle sclk level", sclk, expCpol);
    clearModel();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitIdle();
    checkTransfer(n, "sweep");
  endtask

  initial begin
    automatic bit resetOk = 1'b1;
    // R1: outputs at defaults while inputs move during reset
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      start = i[0]; txPush = 1'b1; txData = 8'(i * 17);
      cfgWrEn = 1'b1; cfgAddr = 2'(i); cfgData = 8'hFF; rxPop = i[1];
      @(posedge clk); #1;
      if (ssN != '1 || sclk || mosi || busy || cfgErr || byteDone || !rxEmpty || txFull) resetOk = 1'b0;
    end
    @(negedge clk);
    start = 0; txPush = 0; cfgWrEn = 0; rxPop = 0;
    rstN = 1'b1;
    @(negedge clk);
    check(resetOk, "R1", "outputs during reset", resetOk, 1);
    check(ssN == '1 && !sclk && !mosi && !busy && !cfgErr && !byteDone, "R1", "outputs after reset", ssN, 4'hF);
    check(rxEmpty && !txFull, "R1", "fifo flags after reset", rxEmpty, 1);

    // R7 and R1: start with empty transmit FIFO does nothing
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check(!busy && ssN == '1, "R7", "start with empty fifo", busy, 0);

    // sweep of modes, dividers, slaves and lengths
    for (int m = 0; m < 4; m++)
      for (int di = 0; di < 3; di++)
        for (int s = 0; s < NSL; s++) begin
          automatic int dv = (di == 0) ? 0 : ((di == 1) ? 1 : 3);
          doTransfer(m, dv, s, 1 + ((m + di + s) % 3));
        end

    // R2: largest divider value
    doTransfer(2, 255, 3, 1);

    // R8: configuration write in the middle of a transfer
    cfgWrite(2'd0, 8'd1);
    cfgWrite(2'd1, 8'd0);
    cfgWrite(2'd2, 8'd1);
    expCpol = 0; expCpha = 0; expHalf = 2; expSel = 1;
    seed++;
    pushByte(txVal(seed, 0));
    pushByte(txVal(seed, 1));
    @(negedge clk);
    clearModel();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    cfgWrite(2'd0, 8'd5);
    check(cfgErr, "R8", "busy write error pulse", cfgErr, 1);
    @(negedge clk);
    check(!cfgErr, "R8", "error pulse length", cfgErr, 0);
    waitIdle();
    check(gapErrs == 0 && trailErrs == 0, "R8", "busy write discarded", gapErrs + trailErrs, 0);
    checkTransfer(2, "busy-write");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule